// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block drives the horizontal sync, vertical sync and data-enable signals of a parallel RGB panel from a single pixel clock. A horizontal pixel counter runs through each line and a vertical line counter runs through each frame. Every edge of every output is a compare position against these counters, so the porch and sync layout is set entirely by the programmed values. Counter position 0 is the first clock of the front porch. A typical programming puts the sync pulse at front-porch..front-porch+sync-width and the active area after the back porch. The line total is then the front porch, sync width, back porch and active width added together, and the frame total is summed the same way in lines.

Configuration is written through a small word-wide write port into shadow copies. The shadow copies take effect only between frames, or at once while the generator is stopped, so a frame is never torn by a partial update. The block also gives each output its own polarity inversion, a run enable, a maskable one-clock frame-done pulse, and the active-area pixel coordinates.

Top module: `lcd_timing_gen`

## Requirements
- R1: Every configuration word and control bit resets to zero. While reset is held or `gen_en` is low, `hsync`, `vsync` and `de` sit at their inactive level (equal to their invert bits), and `pix_x`, `pix_y` and `frame_done` are 0.
- R2: The horizontal count steps 0,1,..,L-1 and wraps, where L is the line total in bits [CW-1:0] of word 0. The vertical count advances when the horizontal count wraps and steps 0..F-1, where F is the frame total in bits [2*CW-1:CW] of word 0. A frame therefore lasts L*F clocks. A total of 0 behaves like 1.
- R3: In every window word the rise position is in bits [CW-1:0] and the fall position in bits [2*CW-1:CW]. The `hsync` active level holds exactly while rise <= h < fall, with the positions taken from word 1. A window whose rise equals its fall is never active.
- R4: The `vsync` start line and end line come from word 2. The start pixel and end pixel within those lines come from word 3. `vsync` is active from (start line, start pixel) up to, but not including, (end line, end pixel), ordered by line first and then by pixel.
- R5: `de` is active when the horizontal count is inside the word 4 window and the vertical count is inside the word 5 window.
- R6: While `de` is active, `pix_x` equals h minus the word 4 rise and `pix_y` equals v minus the word 5 rise. Otherwise both are 0.
- R7: In word 6, bit 0 inverts `hsync`, bit 1 inverts `vsync` and bit 2 inverts `de`. Writes to address 7 are ignored.
- R8: `frame_done` is high for the single clock in which h = L-1 and v = F-1, provided word 6 bit 3 is set. With bit 3 clear it stays low.
- R9: A write lands in a shadow copy. The shadow is copied to the working set at the clock edge that ends a frame, or at every edge while `gen_en` is low. Outputs follow the working set only.
- R10: Dropping `gen_en` clears both counters on the next edge. When `gen_en` is raised again, the first clock is position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_en | input | 1 | Run enable for the counters and outputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select (0 to 6) |
| cfg_wdata | input | 2*CW | Configuration write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | CW | Active-area column, 0 outside `de` |
| pix_y | output | CW | Active-area row, 0 outside `de` |
| frame_done | output | 1 | One-clock end-of-frame pulse |

## Verification
The bench builds the block with the default CW = 12. It programs line totals of 6 to 20 clocks and frame totals of 3 to 8 lines, so a single run covers dozens of complete frames. With these small totals, window edges land at line starts, line ends and the last line of a frame, equal rise and fall positions come up often, and windows reaching exactly the total occur. Random rewrites made while the generator runs check that shadow updates wait for the frame boundary. Random enable drops check the restart at position (0,0).

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 12,
  localparam int DW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          frame_done
);

  localparam int NW = 6;

  logic [DW-1:0] pend [NW];
  logic [DW-1:0] act  [NW];
  logic [3:0]    pend_ctl, act_ctl;
  logic [CW-1:0] hcnt, vcnt;
  logic          h_last, v_last, f_last;

  wire [CW-1:0] h_tot = act[0][CW-1:0];
  wire [CW-1:0] v_tot = act[0][DW-1:CW];
  wire [CW-1:0] hs_r  = act[1][CW-1:0];
  wire [CW-1:0] hs_f  = act[1][DW-1:CW];
  wire [CW-1:0] vs_lr = act[2][CW-1:0];
  wire [CW-1:0] vs_lf = act[2][DW-1:CW];
  wire [CW-1:0] vs_pr = act[3][CW-1:0];
  wire [CW-1:0] vs_pf = act[3][DW-1:CW];
  wire [CW-1:0] de_hr = act[4][CW-1:0];
  wire [CW-1:0] de_hf = act[4][DW-1:CW];
  wire [CW-1:0] de_vr = act[5][CW-1:0];
  wire [CW-1:0] de_vf = act[5][DW-1:CW];

  assign h_last = ({1'b0, hcnt} + 1'b1) >= {1'b0, h_tot};
  assign v_last = ({1'b0, vcnt} + 1'b1) >= {1'b0, v_tot};
  assign f_last = gen_en && h_last && v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        pend[i] <= '0;
        act[i]  <= '0;
      end
      pend_ctl <= '0;
      act_ctl  <= '0;
    end else begin
      if (cfg_we && cfg_addr < 3'(NW)) pend[cfg_addr] <= cfg_wdata;
      if (cfg_we && cfg_addr == 3'(NW)) pend_ctl <= cfg_wdata[3:0];
      if (!gen_en || f_last) begin
        for (int i = 0; i < NW; i++) act[i] <= pend[i];
        act_ctl <= pend_ctl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!gen_en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  logic hs_on, vs_on, de_on, vs_after, vs_before;

  assign hs_on     = (hcnt >= hs_r) && (hcnt < hs_f);
  assign vs_after  = (vcnt > vs_lr) || ((vcnt == vs_lr) && (hcnt >= vs_pr));
  assign vs_before = (vcnt < vs_lf) || ((vcnt == vs_lf) && (hcnt < vs_pf));
  assign vs_on     = vs_after && vs_before;
  assign de_on     = gen_en && (hcnt >= de_hr) && (hcnt < de_hf)
                            && (vcnt >= de_vr) && (vcnt < de_vf);

  assign hsync      = (gen_en && hs_on) ^ act_ctl[0];
  assign vsync      = (gen_en && vs_on) ^ act_ctl[1];
  assign de         = de_on ^ act_ctl[2];
  assign pix_x      = de_on ? hcnt - de_hr : '0;
  assign pix_y      = de_on ? vcnt - de_vr : '0;
  assign frame_done = f_last && act_ctl[3];

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (hcnt == '0 && vcnt == '0)) else $error("idle counters"); // R10

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && gen_en && hcnt != '0) |-> hcnt == $past(hcnt) + 1'b1)
    else $error("h step"); // R2

  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && gen_en && hcnt != '0) |-> $stable(vcnt))
    else $error("v hold"); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && pend[0][CW-1:0] > CW'(1)) |=> !frame_done)
    else $error("done width"); // R8

  AST_PIX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (pix_x == '0 && pix_y == '0 && !frame_done))
    else $error("idle pixels"); // R1

endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
  localparam int CLK_NS = 10;
  localparam int CW = 12;
  localparam int DW = 2 * CW;

  logic clk = 0, rst_n = 0, gen_en = 0, cfg_we = 0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic hsync, vsync, de, frame_done;
  logic [CW-1:0] pix_x, pix_y;

  int checks = 0, errors = 0;
  bit chk_on = 0, done_msg = 0;

  lcd_timing_gen #(.CW(CW)) u_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .frame_done(frame_done));

  always #(CLK_NS/2) clk = ~clk;

  // Reference state built from the requirements
  int mh = 0, mv = 0;
  logic [DW-1:0] mpend [7];
  logic [DW-1:0] mact  [7];

  function automatic int lo(input logic [DW-1:0] w); return int'(w[CW-1:0]); endfunction
  function automatic int hi(input logic [DW-1:0] w); return int'(w[DW-1:CW]); endfunction
  function automatic bit win(input logic [DW-1:0] w, input int c);
    return (lo(w) <= c) && (c < hi(w));
  endfunction
  function automatic bit last_frame();
    return (mh + 1 >= lo(mact[0])) && (mv + 1 >= hi(mact[0]));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin mpend[i] <= '0; mact[i] <= '0; end
      mh <= 0; mv <= 0;
    end else begin
      if (cfg_we && cfg_addr != 3'd7) mpend[cfg_addr] <= cfg_wdata;
      if (!gen_en || last_frame())
        for (int i = 0; i < 7; i++) mact[i] <= mpend[i];
      if (!gen_en) begin mh <= 0; mv <= 0; end
      else if (mh + 1 >= lo(mact[0])) begin
        mh <= 0;
        mv <= (mv + 1 >= hi(mact[0])) ? 0 : mv + 1;
      end else mh <= mh + 1;
    end
  end

  function automatic bit exp_hs();
    return (gen_en && win(mact[1], mh)) ^ mact[6][0];
  endfunction
  function automatic bit exp_vs();
    bit a, b;
    a = (mv > lo(mact[2])) || (mv == lo(mact[2]) && mh >= lo(mact[3]));
    b = (mv < hi(mact[2])) || (mv == hi(mact[2]) && mh < hi(mact[3]));
    return (gen_en && a && b) ^ mact[6][1];
  endfunction
  function automatic bit exp_de_on();
    return gen_en && win(mact[4], mh) && win(mact[5], mv);
  endfunction
  function automatic bit exp_done();
    return gen_en && mact[6][3] && last_frame();
  endfunction

  task automatic chk(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act_v, exp_v, mh, mv);
    end
  endtask

  always @(negedge clk) if (chk_on && rst_n) begin
    chk("R3 R7 R9 hsync", int'(hsync), int'(exp_hs()));
    chk("R4 R7 vsync", int'(vsync), int'(exp_vs()));
    chk("R5 R7 R10 de", int'(de), int'(exp_de_on() ^ mact[6][2]));
    chk("R6 pix_x", int'(pix_x), exp_de_on() ? (mh - lo(mact[4])) & 12'hFFF : 0);
    chk("R6 pix_y", int'(pix_y), exp_de_on() ? (mv - lo(mact[5])) & 12'hFFF : 0);
    chk("R8 frame_done", int'(frame_done), int'(exp_done()));
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = d;
    tick(1);
    cfg_we = 0;
  endtask

  function automatic logic [DW-1:0] pk(input int r, input int f);
    return {12'(f), 12'(r)};
  endfunction

  task automatic rand_cfg(input int ht, input int vt);
    int r;
    wr(0, pk(ht, vt));
    r = $urandom_range(0, ht); wr(1, pk(r, $urandom_range(r, ht)));
    r = $urandom_range(0, vt - 1); wr(2, pk(r, $urandom_range(r, vt - 1)));
    wr(3, pk($urandom_range(0, ht - 1), $urandom_range(0, ht - 1)));
    r = $urandom_range(0, ht); wr(4, pk(r, $urandom_range(r, ht)));
    r = $urandom_range(0, vt); wr(5, pk(r, $urandom_range(r, vt)));
    wr(6, DW'($urandom_range(0, 15)));
    if ($urandom_range(0, 3) == 0) wr(7, '1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done_msg) begin
      done_msg = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    int t0, t1;
    void'($urandom(32'd4242));
    tick(4);
    // R1: outputs while in reset
    chk("R1 reset hsync", int'(hsync), 0);
    chk("R1 reset vsync", int'(vsync), 0);
    chk("R1 reset de", int'(de), 0);
    chk("R1 reset pix", int'(pix_x) + int'(pix_y), 0);
    chk("R1 reset done", int'(frame_done), 0);
    rst_n = 1;
    tick(2);
    chk_on = 1;

    // Directed: equal rise/fall, address 7 ignored, irq on
    wr(0, pk(8, 4));
    wr(1, pk(3, 3));
    wr(2, pk(1, 2)); wr(3, pk(2, 5));
    wr(4, pk(0, 8)); wr(5, pk(0, 4));
    wr(6, DW'(4'b1000));
    wr(7, '1);
    tick(2);
    gen_en = 1;
    // R2: period between frame_done pulses equals L*F
    t0 = -1; t1 = -1;
    for (int c = 0; c < 200 && t1 < 0; c++) begin
      @(negedge clk);
      if (frame_done) begin if (t0 < 0) t0 = c; else t1 = c; end
      #1;
    end
    chk("R2 frame period", t1 - t0, 32);
    tick(5);

    // Mid-frame rewrite must wait for the frame boundary (R9)
    wr(1, pk(0, 8));
    tick(40);

    // Random configurations with enable drops (R10)
    for (int it = 0; it < 40; it++) begin
      int ht, vt;
      ht = $urandom_range(6, 20);
      vt = $urandom_range(3, 8);
      if ($urandom_range(0, 1) == 0) begin gen_en = 0; tick(1); end
      rand_cfg(ht, vt);
      gen_en = 1;
      tick($urandom_range(1, 3) * ht * vt + $urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0) begin
        gen_en = 0; tick($urandom_range(1, 4));
        gen_en = 1; tick(ht * vt);
      end
    end

    gen_en = 0;
    tick(3);
    // R1: idle outputs follow invert bits, pixels zero
    chk("R1 idle pix", int'(pix_x) + int'(pix_y), 0);
    chk("R1 idle done", int'(frame_done), 0);
    chk_on = 0;
    if (!done_msg) begin
      done_msg = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule